// File: doc/BRIEF.md
# Audio Codec Control Register File

This block is the indexed control register bank of a multichannel audio codec. A host reaches it through a parallel register port with a 7-bit index, 16-bit write data, a write strobe and a read strobe. The bank holds the output volume and mute registers, the record-source selection and two configuration words. From these it drives decoded 5-bit attenuation codes and mute flags for the line, headphone, mono, center, LFE, surround and PCM output paths, plus the two 3-bit record-source codes.

Writes apply the bank's own rules as they land. A volume field saturates when its overflow bit is set. An odd index reaches the even register just below it. A write to index 00h restores the bank's defaults, except the serial-configuration word, which keeps its value. The split-mute enable decides whether bit 7 has any effect. The routing bit decides which volume register feeds the center, LFE and surround attenuators.

The register port is a plain control interface with no back-pressure. The bank accepts every strobe in the cycle it is presented. A read strobe returns its data one cycle later with `rd_valid` high.

Top module: `acodec_regbank`

## Requirements
- R1: A volume field with its overflow bit clear (left field bits 12:8 with overflow bit 13; right or mono field bits 4:0 with overflow bit 5) stores the 5-bit value written. That value appears on the attenuation output and reads back in place. 0 means no attenuation and 31 the most, in 1.5 dB steps.
- R2: Writing a volume field with its overflow bit (13 or 5) set stores 31 in that field. The field's five bits read back as ones, and the overflow bits read as 0.
- R3: Bit 15 mutes the left channel of a stereo volume register. Bit 7 mutes the right channel only while split mute (register 76h bit 0) is 1. While split mute is 0, bit 15 mutes both channels and bit 7 has no effect on any output, though it still reads back.
- R4: An odd index addresses the even register one below it, for both reads and writes.
- R5: A write of any value to index 00h returns every register to its default in the next cycle, except register 74h (bits 3:0 stored), which keeps its value.
- R6: A read of index 00h returns {6'b0, ID_CODE}: bits 9:0 carry the capability code and the enhancement field in bits 14:10 is zero.
- R7: With routing bit (76h bit 1) at 0, master (02h) drives line out only, and PCM (18h) drives the PCM, surround, center (from its left field) and LFE (from its right field) paths. With the bit at 1, master drives line out, center (left field) and LFE (right field), PCM drives only the PCM path, and surround is muted at attenuation 31.
- R8: Record select (1Ah) resets to 0000h, selecting source 0 (microphone) on both channels. Bits 10:8 drive the left source code and bits 2:0 the right.
- R9: Mono volume (06h) has a single field in bits 5:0 with the same overflow rule, and a mute in bit 15. It drives the mono path.
- R10: Volume registers (02h, 04h, 06h, 18h) default to 8000h (muted, attenuation 0). Reserved bits and unimplemented indexes read as zero, and writes to them have no effect.
- R11: A power-on reset sets every register to its default, including register 74h, which clears to 0000h.
- R12: `rd_data` and `rd_valid` are registered one cycle after `rd_en`. A read in the same cycle as a write to the same register returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| reg_idx | input | 7 | Register index (bit 0 ignored) |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, valid one cycle after rd_en |
| rd_valid | output | 1 | High in the cycle rd_data holds a read result |
| atten_o | output | 55 | 5-bit attenuation per path, path k in bits 5k+4:5k (order: line L, line R, headphone L, headphone R, mono, center, LFE, surround L, surround R, PCM L, PCM R) |
| mute_o | output | 11 | Mute flag per path, same order |
| rec_src_l | output | 3 | Left record source code |
| rec_src_r | output | 3 | Right record source code |

## Verification
A read and a write can fall in the same cycle, so the bench presents both strobes on one edge to the same register. It expects `rd_data` to carry the pre-write word while the outputs already show the new one. A read can also land in the same cycle as a write to index 00h. The bench checks that this read returns the old value, and that the following read and the outputs show the defaults while register 74h is unchanged. The volume fields are swept over all 64 written codes through both the even and the odd index. The expected codes are computed arithmetically from the saturation rule.

// File: rtl/acodec_pkg.sv
package acodec_pkg;
  localparam int IDXW  = 7;
  localparam int DW    = 16;
  localparam int AW    = 5;
  localparam int NCH   = 11;
  localparam int SRCW  = 3;
  localparam int SERW  = 4;

  // word addresses (index >> 1)
  localparam logic [IDXW-2:0] WA_RESET  = 6'h00;
  localparam logic [IDXW-2:0] WA_MASTER = 6'h01;
  localparam logic [IDXW-2:0] WA_HPHONE = 6'h02;
  localparam logic [IDXW-2:0] WA_MONO   = 6'h03;
  localparam logic [IDXW-2:0] WA_PCM    = 6'h0C;
  localparam logic [IDXW-2:0] WA_RECSEL = 6'h0D;
  localparam logic [IDXW-2:0] WA_SERCFG = 6'h3A;
  localparam logic [IDXW-2:0] WA_MISC   = 6'h3B;

  // path order on atten_o / mute_o
  localparam int CH_LINE_L = 0;
  localparam int CH_LINE_R = 1;
  localparam int CH_HP_L   = 2;
  localparam int CH_HP_R   = 3;
  localparam int CH_MONO   = 4;
  localparam int CH_CENTER = 5;
  localparam int CH_LFE    = 6;
  localparam int CH_SURR_L = 7;
  localparam int CH_SURR_R = 8;
  localparam int CH_PCM_L  = 9;
  localparam int CH_PCM_R  = 10;

  typedef struct packed {
    logic          mute_hi;
    logic [AW-1:0] att_hi;
    logic          mute_lo;
    logic [AW-1:0] att_lo;
  } vol_t;

  localparam vol_t VOL_DEFAULT = '{mute_hi: 1'b1, att_hi: '0, mute_lo: 1'b0, att_lo: '0};

  function automatic logic [AW-1:0] sat_field(input logic ovf, input logic [AW-1:0] v);
    return ovf ? {AW{1'b1}} : v;
  endfunction
endpackage

// File: rtl/acodec_vol_reg.sv
module acodec_vol_reg
  import acodec_pkg::*;
#(
  parameter bit STEREO = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output vol_t          q,
  output logic [DW-1:0] rd_word
);
  vol_t nxt;

  generate
    if (STEREO) begin : g_stereo
      always_comb begin
        nxt.mute_hi = wr_data[15];
        nxt.att_hi  = sat_field(wr_data[13], wr_data[12:8]);
        nxt.mute_lo = wr_data[7];
        nxt.att_lo  = sat_field(wr_data[5], wr_data[4:0]);
      end
    end else begin : g_mono
      always_comb begin
        nxt.mute_hi = wr_data[15];
        nxt.att_hi  = '0;
        nxt.mute_lo = 1'b0;
        nxt.att_lo  = sat_field(wr_data[5], wr_data[4:0]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= VOL_DEFAULT;
    else if (soft_rst) q <= VOL_DEFAULT;
    else if (wr_sel)   q <= nxt;
  end

  assign rd_word = {q.mute_hi, 2'b00, q.att_hi, q.mute_lo, 2'b00, q.att_lo};
endmodule

// File: rtl/acodec_route.sv
module acodec_route
  import acodec_pkg::*;
(
  input  vol_t               master,
  input  vol_t               hphone,
  input  vol_t               mono,
  input  vol_t               pcm,
  input  logic               split_en,
  input  logic               compat,
  output logic [NCH*AW-1:0]  atten_o,
  output logic [NCH-1:0]     mute_o
);
  logic [AW-1:0] att [NCH];
  logic          mut [NCH];

  function automatic logic rmute(input vol_t v, input logic split);
    return split ? v.mute_lo : v.mute_hi;
  endfunction

  always_comb begin
    att[CH_LINE_L] = master.att_hi;  mut[CH_LINE_L] = master.mute_hi;
    att[CH_LINE_R] = master.att_lo;  mut[CH_LINE_R] = rmute(master, split_en);
    att[CH_HP_L]   = hphone.att_hi;  mut[CH_HP_L]   = hphone.mute_hi;
    att[CH_HP_R]   = hphone.att_lo;  mut[CH_HP_R]   = rmute(hphone, split_en);
    att[CH_MONO]   = mono.att_lo;    mut[CH_MONO]   = mono.mute_hi;
    att[CH_PCM_L]  = pcm.att_hi;     mut[CH_PCM_L]  = pcm.mute_hi;
    att[CH_PCM_R]  = pcm.att_lo;     mut[CH_PCM_R]  = rmute(pcm, split_en);
    if (compat) begin
      att[CH_CENTER] = master.att_hi;  mut[CH_CENTER] = master.mute_hi;
      att[CH_LFE]    = master.att_lo;  mut[CH_LFE]    = rmute(master, split_en);
      att[CH_SURR_L] = {AW{1'b1}};     mut[CH_SURR_L] = 1'b1;
      att[CH_SURR_R] = {AW{1'b1}};     mut[CH_SURR_R] = 1'b1;
    end else begin
      att[CH_CENTER] = pcm.att_hi;     mut[CH_CENTER] = pcm.mute_hi;
      att[CH_LFE]    = pcm.att_lo;     mut[CH_LFE]    = rmute(pcm, split_en);
      att[CH_SURR_L] = pcm.att_hi;     mut[CH_SURR_L] = pcm.mute_hi;
      att[CH_SURR_R] = pcm.att_lo;     mut[CH_SURR_R] = rmute(pcm, split_en);
    end
  end

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_pack
      assign atten_o[k*AW +: AW] = att[k];
      assign mute_o[k]           = mut[k];
    end
  endgenerate
endmodule

// File: rtl/acodec_regbank.sv
module acodec_regbank
  import acodec_pkg::*;
#(
  parameter logic [9:0] ID_CODE = 10'h250
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDXW-1:0]     reg_idx,
  input  logic [DW-1:0]       wr_data,
  input  logic                wr_en,
  input  logic                rd_en,
  output logic [DW-1:0]       rd_data,
  output logic                rd_valid,
  output logic [NCH*AW-1:0]   atten_o,
  output logic [NCH-1:0]      mute_o,
  output logic [SRCW-1:0]     rec_src_l,
  output logic [SRCW-1:0]     rec_src_r
);
  localparam int NVOL = 4;
  localparam logic [IDXW-2:0] VOL_WA [NVOL] = '{WA_MASTER, WA_HPHONE, WA_MONO, WA_PCM};
  localparam bit              VOL_ST [NVOL] = '{1'b1, 1'b1, 1'b0, 1'b1};

  logic [IDXW-2:0] wa;
  logic            soft_rst;
  vol_t            vq  [NVOL];
  logic [DW-1:0]   vrd [NVOL];
  logic            split_en, compat;
  logic [SERW-1:0] sercfg;
  logic [DW-1:0]   rd_mux;

  assign wa       = reg_idx[IDXW-1:1];
  assign soft_rst = wr_en && (wa == WA_RESET);

  generate
    for (genvar i = 0; i < NVOL; i++) begin : g_vol
      acodec_vol_reg #(.STEREO(VOL_ST[i])) u_vol (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .wr_sel  (wr_en && (wa == VOL_WA[i])),
        .wr_data (wr_data),
        .q       (vq[i]),
        .rd_word (vrd[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_src_l <= '0;
      rec_src_r <= '0;
      split_en  <= 1'b0;
      compat    <= 1'b0;
    end else if (soft_rst) begin
      rec_src_l <= '0;
      rec_src_r <= '0;
      split_en  <= 1'b0;
      compat    <= 1'b0;
    end else if (wr_en) begin
      if (wa == WA_RECSEL) begin
        rec_src_l <= wr_data[8 +: SRCW];
        rec_src_r <= wr_data[0 +: SRCW];
      end
      if (wa == WA_MISC) begin
        split_en <= wr_data[0];
        compat   <= wr_data[1];
      end
    end
  end

  // serial configuration survives the register-reset write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          sercfg <= '0;
    else if (wr_en && wa == WA_SERCFG)   sercfg <= wr_data[SERW-1:0];
  end

  always_comb begin
    rd_mux = '0;
    case (wa)
      WA_RESET:  rd_mux = {6'b0, ID_CODE};
      WA_MASTER: rd_mux = vrd[0];
      WA_HPHONE: rd_mux = vrd[1];
      WA_MONO:   rd_mux = vrd[2];
      WA_PCM:    rd_mux = vrd[3];
      WA_RECSEL: rd_mux = {5'b0, rec_src_l, 5'b0, rec_src_r};
      WA_SERCFG: rd_mux = {{(DW-SERW){1'b0}}, sercfg};
      WA_MISC:   rd_mux = {14'b0, compat, split_en};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  acodec_route u_route (
    .master  (vq[0]),
    .hphone  (vq[1]),
    .mono    (vq[2]),
    .pcm     (vq[3]),
    .split_en(split_en),
    .compat  (compat),
    .atten_o (atten_o),
    .mute_o  (mute_o)
  );
endmodule

// File: rtl/acodec_regbank_chk.sv
module acodec_regbank_chk
  import acodec_pkg::*;
#(
  parameter logic [9:0] ID_CODE = 10'h250
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDXW-1:0]   reg_idx,
  input logic [DW-1:0]     wr_data,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DW-1:0]     rd_data,
  input logic              rd_valid,
  input logic [NCH*AW-1:0] atten_o,
  input logic [NCH-1:0]    mute_o,
  input logic              split_en,
  input logic              compat
);
  p_sat_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx[IDXW-1:1] == WA_MASTER && wr_data[5])
      |=> (atten_o[CH_LINE_R*AW +: AW] == {AW{1'b1}}));

  p_id_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_idx[IDXW-1:1] == WA_RESET) |=> (rd_data == {6'b0, ID_CODE}));

  p_soft_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx[IDXW-1:1] == WA_RESET)
      |=> (mute_o[CH_LINE_L] && atten_o[CH_LINE_L*AW +: AW] == '0 && !split_en && !compat));

  p_no_split_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !split_en |-> (mute_o[CH_LINE_L] == mute_o[CH_LINE_R]));

  p_surround_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    compat |-> (mute_o[CH_SURR_L] && mute_o[CH_SURR_R]));

  p_rd_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

bind acodec_regbank acodec_regbank_chk #(.ID_CODE(ID_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_data(wr_data),
  .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
  .atten_o(atten_o), .mute_o(mute_o), .split_en(split_en), .compat(compat)
);

// File: tb/tb_acodec_regbank.sv
module tb_acodec_regbank;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [9:0] ID = 10'h250;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  reg_idx = '0;
  logic [15:0] wr_data = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [54:0] atten_o;
  logic [10:0] mute_o;
  logic [2:0]  rec_src_l, rec_src_r;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acodec_regbank #(.ID_CODE(ID)) dut (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_data(wr_data),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .atten_o(atten_o), .mute_o(mute_o), .rec_src_l(rec_src_l), .rec_src_r(rec_src_r)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] idx, input logic [15:0] d);
    @(negedge clk);
    reg_idx = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] idx, output logic [15:0] d);
    @(negedge clk);
    reg_idx = idx; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R12 valid", rd_valid, 1);
    d = rd_data;
  endtask

  function automatic logic [4:0] att(input int ch);
    return atten_o[ch*5 +: 5];
  endfunction

  function automatic logic [4:0] satv(input logic [5:0] v);
    return v[5] ? 5'd31 : v[4:0];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R10 line_l mute", mute_o[0], 1);
    chk("R10 line_l att", att(0), 0);
    chk("R10 mono mute", mute_o[4], 1);
    chk("R8 rec l", rec_src_l, 0);
    chk("R8 rec r", rec_src_r, 0);
    rd(7'h02, d); chk("R10 master default", d, 16'h8000);
    rd(7'h1A, d); chk("R8 recsel default", d, 16'h0000);
    rd(7'h00, d); chk("R6 id word", d, {6'b0, ID});

    // R1 R2 R4: sweep every 6-bit code via even and odd index
    for (int v = 0; v < 64; v++) begin
      logic [5:0] l6 = 6'(v), r6 = 6'(63 - v);
      wr((v % 2) ? 7'h03 : 7'h02, {2'b00, l6, 2'b00, r6});
      chk("R1/R2 line_l att", att(0), satv(l6));
      chk("R1/R2 line_r att", att(1), satv(r6));
      rd((v % 2) ? 7'h02 : 7'h03, d);
      chk("R2 R4 readback", d, {3'b0, satv(l6), 3'b0, satv(r6)});
    end

    // R9: mono sweep
    for (int v = 0; v < 64; v++) begin
      wr(7'h06, {1'b0, 9'b0, 6'(v)});
      chk("R9 mono att", att(4), satv(6'(v)));
      chk("R9 mono unmuted", mute_o[4], 0);
    end
    rd(7'h07, d); chk("R9 mono readback", d, 16'h001F);

    // R3: split mute combinations on headphone
    for (int s = 0; s < 2; s++) begin
      wr(7'h76, 16'(s));
      for (int m = 0; m < 4; m++) begin
        logic m15 = m[1], m7 = m[0];
        wr(7'h04, {m15, 7'b0, m7, 7'h03});
        chk("R3 hp l mute", mute_o[2], m15);
        chk("R3 hp r mute", mute_o[3], s ? m7 : m15);
        rd(7'h04, d); chk("R3 bit7 readback", d[7], m7);
      end
    end

    // R7: routing
    wr(7'h02, 16'h0A05);
    wr(7'h18, 16'h1411);
    for (int c = 0; c < 2; c++) begin
      wr(7'h76, 16'(c << 1));
      chk("R7 line_l", att(0), 5'h0A);
      chk("R7 pcm_l", att(9), 5'h14);
      chk("R7 pcm_r", att(10), 5'h11);
      chk("R7 center", att(5), c ? 5'h0A : 5'h14);
      chk("R7 lfe", att(6), c ? 5'h05 : 5'h11);
      chk("R7 surr_l", att(7), c ? 5'h1F : 5'h14);
      chk("R7 surr_r att", att(8), c ? 5'h1F : 5'h11);
      chk("R7 surr_r mute", mute_o[8], c ? 1 : 0);
      chk("R7 center mute", mute_o[5], 0);
    end

    // R8: record select fields
    wr(7'h1A, 16'hFFFF);
    chk("R8 rec l", rec_src_l, 7);
    chk("R8 rec r", rec_src_r, 7);
    rd(7'h1A, d); chk("R10 recsel reserved", d, 16'h0707);
    wr(7'h1A, 16'h0502);
    chk("R8 rec l val", rec_src_l, 5);
    chk("R8 rec r val", rec_src_r, 2);

    // R10: reserved bits and unimplemented indexes
    wr(7'h02, 16'hFFFF);
    rd(7'h02, d); chk("R10 vol reserved", d, 16'h9F9F);
    wr(7'h30, 16'hFFFF);
    rd(7'h30, d); chk("R10 unimpl read", d, 0);
    rd(7'h02, d); chk("R10 unimpl write no effect", d, 16'h9F9F);
    wr(7'h76, 16'hFFFC);
    rd(7'h76, d); chk("R10 misc reserved", d, 0);

    // R12: same-cycle read and write
    wr(7'h02, 16'h0102);
    @(negedge clk);
    reg_idx = 7'h02; wr_data = 16'h0304; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R12 old value", rd_data, 16'h0102);
    chk("R12 outputs new", att(0), 5'h03);

    // R5: register reset write, 74h kept, read in same cycle
    wr(7'h74, 16'h0005);
    wr(7'h1A, 16'h0304);
    @(negedge clk);
    reg_idx = 7'h00; wr_data = 16'h1234; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R5 R12 read during reset", rd_data, {6'b0, ID});
    chk("R5 line_l mute", mute_o[0], 1);
    chk("R5 line_l att", att(0), 0);
    chk("R5 rec l", rec_src_l, 0);
    rd(7'h02, d); chk("R5 master default", d, 16'h8000);
    rd(7'h1A, d); chk("R5 recsel default", d, 0);
    rd(7'h75, d); chk("R5 R4 sercfg kept", d, 16'h0005);

    // R11: power-on reset clears 74h
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(7'h74, d); chk("R11 sercfg cleared", d, 0);
    chk("R11 mono muted", mute_o[4], 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule